// File: doc/BRIEF.md
# Programmable-Edge SPI Master

This block moves one word at a time over a serial link as the bus master. A single-cycle start pulse launches a transfer. The block then drives a slave-select line, toggles a serial clock derived from the system clock, shifts the transmit word out most significant bit first, and collects the same number of bits from the input line. When the transfer ends it reports the received word with a one-cycle done pulse.

Each physical detail of the link is set by its own control input. These cover:
- the clock's resting level,
- which clock edge updates outgoing data,
- which clock edge samples incoming data,
- the active level of the select line,
- the choice between separate in/out data lines and a single shared line whose direction is chosen per word.

All of these, together with the clock divider, are captured when a transfer starts. Changing them while a word is in flight has no effect.

Top module: `spi_xfer_master`

## Requirements
- R1: The serial clock rests at the level of `cfg_idle_hi` (1 = high, 0 = low). Outside a transfer it follows that input one cycle later. At the end of a transfer it is back at the latched resting level.
- R2: Outgoing data on `mosi` changes only on serial-clock edges of the kind chosen by `cfg_tx_fall` (1 = falling, 0 = rising). The first edge of a word never shifts the data.
- R3: Incoming data is sampled on edges of the kind chosen by `cfg_rx_fall` (1 = falling, 0 = rising), independently of `cfg_tx_fall`. There are exactly WORD_W such samples per word.
- R4: `sel_out` sits at the level given by `cfg_sel_hi` (1 = active high, 0 = active low) while busy, and at the opposite level otherwise. Its reset value is 1.
- R5: Words are WORD_W bits (8 to 32). They are sent and received most significant bit first, and `rx_word` holds the first sampled bit in bit WORD_W-1.
- R6: With `cfg_half` = 1 and `cfg_dir_tx` = 0, `mosi_oe` is 0 for the whole transfer. In half-duplex mode, received bits come from `sio_in`.
- R7: With `cfg_half` = 0, received bits come from `miso`. `mosi_oe` is 1 whenever no half-duplex receive is in progress.
- R8: Let D be `div_cnt` (D = 0 is treated as 1). Select becomes active one cycle after start. The first clock edge follows D cycles later, successive edges are D cycles apart, and select goes inactive D cycles after the last edge.
- R9: `done` is high for exactly one cycle as select goes inactive. `rx_word` takes its new value in that same cycle and holds it until the next done.
- R10: Configuration inputs, `div_cnt` and `tx_word` are latched at start. Changing them, or pulsing `start`, while `busy` is high has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a word |
| tx_word | input | WORD_W | Word to send |
| div_cnt | input | DIV_W | Serial-clock half period in system cycles |
| cfg_idle_hi | input | 1 | Serial clock resting level |
| cfg_tx_fall | input | 1 | 1: transmit on falling edge, 0: on rising edge |
| cfg_rx_fall | input | 1 | 1: sample on falling edge, 0: on rising edge |
| cfg_sel_hi | input | 1 | 1: select active high, 0: active low |
| cfg_half | input | 1 | 1: single shared data line |
| cfg_dir_tx | input | 1 | Half-duplex direction, 1: transmit, 0: receive |
| miso | input | 1 | Serial input in full-duplex mode |
| sio_in | input | 1 | Shared line input in half-duplex mode |
| sclk | output | 1 | Serial clock |
| sel_out | output | 1 | Slave select |
| mosi | output | 1 | Serial data out (also drives the shared line) |
| mosi_oe | output | 1 | Output enable for the data line |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-word pulse |
| rx_word | output | WORD_W | Last received word |

## Verification
Transfers are run with all eight combinations of resting level, transmit edge and sample edge. This separates the two edge selections from each other and from the polarity, because a swapped edge shifts the data by half a bit, which the every-cycle model comparison catches. Divider values 0, 1, 2 and 3 separate the zero-clamp and the lead/trail spacing from the edge spacing. Half-duplex words in both directions, taken with the input lines carrying different random streams, show which line is sampled and when the output enable drops. A run whose configuration and start input are disturbed mid-word confirms that the latched settings govern the transfer.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  typedef struct packed {
    logic idle_hi;
    logic tx_fall;
    logic rx_fall;
    logic sel_hi;
    logic half;
    logic dir_tx;
  } spi_cfg_t;
endpackage

// File: rtl/spi_sclk_timer.sv
module spi_sclk_timer #(
  parameter int DIV_W = 8,
  parameter int EDGES = 32,
  localparam int TK_W = $clog2(EDGES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output logic             tick,
  output logic [TK_W-1:0]  tk
);
  localparam logic [TK_W-1:0] TK_LAST = TK_W'(EDGES);

  logic [DIV_W-1:0] div_r;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_eff;

  assign div_eff = (div_in == '0) ? DIV_W'(1) : div_in;
  assign tick    = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_r <= DIV_W'(1);
      cnt   <= '0;
      tk    <= '0;
    end else if (load) begin
      div_r <= div_eff;
      cnt   <= div_eff - DIV_W'(1);
      tk    <= '0;
    end else if (run) begin
      if (cnt == '0) begin
        cnt <= div_r - DIV_W'(1);
        if (tk != TK_LAST) tk <= tk + TK_W'(1);
      end else begin
        cnt <= cnt - DIV_W'(1);
      end
    end
  end

  a_r8_tk_bound: assert property (@(posedge clk) disable iff (rst) tk <= TK_LAST);
  a_r8_div_nonzero: assert property (@(posedge clk) disable iff (rst) div_r != '0);
endmodule

// File: rtl/spi_shift_pair.sv
module spi_shift_pair #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              tx_step,
  input  logic              rx_step,
  input  logic              rx_bit,
  output logic              tx_bit,
  output logic [WORD_W-1:0] rx_data
);
  logic [WORD_W-1:0] tx_sh;
  logic [WORD_W-1:0] rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh <= '0;
    end else if (load) begin
      tx_sh <= load_word;
    end else if (tx_step) begin
      tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sh <= '0;
    end else if (rx_step) begin
      rx_sh <= {rx_sh[WORD_W-2:0], rx_bit};
    end
  end

  assign tx_bit  = tx_sh[WORD_W-1];
  assign rx_data = rx_sh;

  a_r5_load_msb: assert property (@(posedge clk) disable iff (rst)
    load |=> tx_bit == $past(load_word[WORD_W-1]));
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_xfer_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  input  logic [DIV_W-1:0]  div_cnt,
  input  logic              cfg_idle_hi,
  input  logic              cfg_tx_fall,
  input  logic              cfg_rx_fall,
  input  logic              cfg_sel_hi,
  input  logic              cfg_half,
  input  logic              cfg_dir_tx,
  input  logic              miso,
  input  logic              sio_in,
  output logic              sclk,
  output logic              sel_out,
  output logic              mosi,
  output logic              mosi_oe,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_word
);
  localparam int EDGES = 2 * WORD_W;
  localparam int TK_W  = $clog2(EDGES + 1);
  localparam logic [TK_W-1:0] TK_LAST = TK_W'(EDGES);

  spi_cfg_t          cfg_in;
  spi_cfg_t          cfg_l;
  logic              accept;
  logic              tick;
  logic [TK_W-1:0]   tk;
  logic              edge_now;
  logic              fin_now;
  logic              tx_step;
  logic              rx_step;
  logic              rx_src;
  logic [WORD_W-1:0] rx_data;
  logic              sclk_r;
  logic              sel_r;
  logic              oe_r;
  logic              busy_r;
  logic              done_r;
  logic [WORD_W-1:0] rx_word_r;

  assign cfg_in = '{idle_hi: cfg_idle_hi, tx_fall: cfg_tx_fall, rx_fall: cfg_rx_fall,
                    sel_hi: cfg_sel_hi, half: cfg_half, dir_tx: cfg_dir_tx};

  assign accept   = start && !busy_r;
  assign edge_now = tick && (tk != TK_LAST);
  assign fin_now  = tick && (tk == TK_LAST);
  assign tx_step  = edge_now && (sclk_r == cfg_l.tx_fall) && (tk != '0);
  assign rx_step  = edge_now && (sclk_r == cfg_l.rx_fall);
  assign rx_src   = cfg_l.half ? sio_in : miso;

  spi_sclk_timer #(.DIV_W(DIV_W), .EDGES(EDGES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .run    (busy_r),
    .div_in (div_cnt),
    .tick   (tick),
    .tk     (tk)
  );

  spi_shift_pair #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_word (tx_word),
    .tx_step   (tx_step),
    .rx_step   (rx_step),
    .rx_bit    (rx_src),
    .tx_bit    (mosi),
    .rx_data   (rx_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_l     <= '0;
      sclk_r    <= 1'b0;
      sel_r     <= 1'b1;
      oe_r      <= 1'b1;
      busy_r    <= 1'b0;
      done_r    <= 1'b0;
      rx_word_r <= '0;
    end else begin
      done_r <= 1'b0;
      if (accept) begin
        cfg_l  <= cfg_in;
        busy_r <= 1'b1;
        sclk_r <= cfg_in.idle_hi;
        sel_r  <= cfg_in.sel_hi;
        oe_r   <= !(cfg_in.half && !cfg_in.dir_tx);
      end else if (busy_r) begin
        if (edge_now) sclk_r <= !sclk_r;
        if (fin_now) begin
          busy_r    <= 1'b0;
          done_r    <= 1'b1;
          sel_r     <= !cfg_l.sel_hi;
          oe_r      <= 1'b1;
          rx_word_r <= rx_data;
        end
      end else begin
        sclk_r <= cfg_in.idle_hi;
        sel_r  <= !cfg_in.sel_hi;
        oe_r   <= 1'b1;
      end
    end
  end

  assign sclk    = sclk_r;
  assign sel_out = sel_r;
  assign mosi_oe = oe_r;
  assign busy    = busy_r;
  assign done    = done_r;
  assign rx_word = rx_word_r;

  a_r1_idle_at_end: assert property (@(posedge clk) disable iff (rst)
    done |-> sclk == cfg_l.idle_hi);
  a_r2_tx_edge_only: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(mosi)) |-> (($past(sclk) == cfg_l.tx_fall) && (sclk != $past(sclk))));
  a_r4_sel_active: assert property (@(posedge clk) disable iff (rst)
    busy |-> sel_out == cfg_l.sel_hi);
  a_r6_oe_off: assert property (@(posedge clk) disable iff (rst)
    (busy && cfg_l.half && !cfg_l.dir_tx) |-> !mosi_oe);
  a_r7_oe_on: assert property (@(posedge clk) disable iff (rst)
    (busy && !cfg_l.half) |-> mosi_oe);
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && sel_out != cfg_l.sel_hi));
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cfg_l));
endmodule

// File: tb/spi_xfer_master_test.sv
`timescale 1ns/1ps
module spi_xfer_master_test;
  localparam int W  = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] tx_word = '0;
  logic [DW-1:0] div_cnt = 8'd1;
  logic cfg_idle_hi = 0, cfg_tx_fall = 0, cfg_rx_fall = 0, cfg_sel_hi = 0, cfg_half = 0, cfg_dir_tx = 0;
  logic miso = 0, sio_in = 0;
  logic sclk, sel_out, mosi, mosi_oe, busy, done;
  logic [W-1:0] rx_word;

  always #2 clk = ~clk;

  spi_xfer_master #(.WORD_W(W), .DIV_W(DW)) uut (
    .clk(clk), .rst(rst), .start(start), .tx_word(tx_word), .div_cnt(div_cnt),
    .cfg_idle_hi(cfg_idle_hi), .cfg_tx_fall(cfg_tx_fall), .cfg_rx_fall(cfg_rx_fall),
    .cfg_sel_hi(cfg_sel_hi), .cfg_half(cfg_half), .cfg_dir_tx(cfg_dir_tx),
    .miso(miso), .sio_in(sio_in), .sclk(sclk), .sel_out(sel_out), .mosi(mosi),
    .mosi_oe(mosi_oe), .busy(busy), .done(done), .rx_word(rx_word)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // behavioural reference model
  bit m_act = 0, m_done = 0;
  int m_c = 0, m_div = 1;
  bit m_idle, m_txf, m_rxf, m_selhi, m_half, m_dir;
  logic [W-1:0] m_tx = '0, m_samp = '0, m_rxw = '0;
  bit m_sclk_idle = 0, m_sel_idle = 1;

  always @(posedge clk) begin
    m_done = 0;
    if (rst) begin
      m_act = 0; m_rxw = '0; m_sclk_idle = 0; m_sel_idle = 1;
    end else if (m_act) begin
      if ((m_c + 1) % m_div == 0) begin
        int k;
        k = (m_c + 1) / m_div - 1;
        if (k < 2 * W && ((m_idle ^ k[0]) == m_rxf))
          m_samp = {m_samp[W-2:0], (m_half ? sio_in : miso)};
      end
      m_c++;
      if (m_c == (2 * W + 1) * m_div) begin
        m_act = 0; m_done = 1; m_rxw = m_samp;
        m_sel_idle = !m_selhi; m_sclk_idle = m_idle;
      end
    end else if (start) begin
      m_act = 1; m_c = 0; m_tx = tx_word;
      m_div = (div_cnt == 0) ? 1 : int'(div_cnt);
      m_idle = cfg_idle_hi; m_txf = cfg_tx_fall; m_rxf = cfg_rx_fall;
      m_selhi = cfg_sel_hi; m_half = cfg_half; m_dir = cfg_dir_tx;
    end else begin
      m_sel_idle = !cfg_sel_hi; m_sclk_idle = cfg_idle_hi;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cycles, act, exp);
    end
  endtask

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (m_act) begin
        int n, s;
        n = m_c / m_div;
        if (n > 2 * W) n = 2 * W;
        s = 0;
        for (int k = 1; k < n; k++) if ((m_idle ^ k[0]) == m_txf) s++;
        chk("R1/R8 sclk", 32'(sclk), 32'(m_idle ^ n[0]));
        chk("R4 sel active", 32'(sel_out), 32'(m_selhi));
        chk("R2/R5 mosi", 32'(mosi), 32'((s < W) ? m_tx[W-1-s] : 1'b0));
        chk("R6/R7 oe", 32'(mosi_oe), 32'(!(m_half && !m_dir)));
        chk("R10 busy", 32'(busy), 32'd1);
      end else begin
        chk("R1 sclk idle", 32'(sclk), 32'(m_sclk_idle));
        chk("R4 sel idle", 32'(sel_out), 32'(m_sel_idle));
        chk("R7 oe idle", 32'(mosi_oe), 32'd1);
        chk("R8 busy idle", 32'(busy), 32'd0);
      end
      chk("R9 done", 32'(done), 32'(m_done));
      chk("R3/R5 rx_word", 32'(rx_word), 32'(m_rxw));
    end
  end

  // input lines carry independent pseudo-random streams
  logic [15:0] lf = 16'hACE1;
  always @(negedge clk) begin
    lf <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    miso <= lf[0];
    sio_in <= lf[7] ^ lf[3];
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic xfer(input bit idl, input bit txf, input bit rxf, input bit sh,
                      input bit hf, input bit dr, input int dv, input logic [W-1:0] w,
                      input bit disturb);
    @(negedge clk);
    cfg_idle_hi = idl; cfg_tx_fall = txf; cfg_rx_fall = rxf; cfg_sel_hi = sh;
    cfg_half = hf; cfg_dir_tx = dr; div_cnt = DW'(dv); tx_word = w; start = 1;
    @(negedge clk);
    start = 0;
    if (disturb) begin
      // R10: change everything and re-pulse start mid-word
      repeat (5) @(negedge clk);
      cfg_idle_hi = !idl; cfg_tx_fall = !txf; cfg_rx_fall = !rxf; cfg_sel_hi = !sh;
      cfg_half = !hf; cfg_dir_tx = !dr; div_cnt = DW'(dv + 2); tx_word = ~w; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state: R4 sel high, R9 done low, R1 sclk low
    chk("R4 reset sel", 32'(sel_out), 32'd1);
    chk("R9 reset done", 32'(done), 32'd0);
    chk("R1 reset sclk", 32'(sclk), 32'd0);
    rst = 0;
    repeat (2) @(negedge clk);
    // R1 R2 R3: all edge/polarity combinations, full duplex
    for (int m = 0; m < 8; m++)
      xfer(m[2], m[1], m[0], m[0] ^ m[2], 0, 0, 1 + (m % 3), 16'hA5C3 ^ 16'(m * 16'h1111), 0);
    // R8 divider zero clamped to one, larger dividers
    xfer(0, 1, 0, 0, 0, 0, 0, 16'h8001, 0);
    xfer(1, 0, 1, 1, 0, 0, 3, 16'h7FFE, 0);
    // R6 half-duplex receive and transmit
    xfer(0, 1, 0, 0, 1, 0, 2, 16'hFFFF, 0);
    xfer(1, 1, 1, 1, 1, 1, 1, 16'h3C96, 0);
    // R10 disturbances while busy
    xfer(0, 0, 1, 0, 0, 0, 2, 16'h1234, 1);
    xfer(1, 1, 0, 1, 1, 0, 1, 16'hBEEF, 1);
    // R5 back-to-back words, all ones / all zeros
    xfer(0, 1, 0, 0, 0, 0, 1, 16'h0000, 0);
    xfer(0, 1, 0, 0, 0, 0, 1, 16'hFFFF, 0);
    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule